// File: doc/BRIEF.md
# Two-Segment Hybrid Binary Adder

This block is a purely combinational N-bit binary adder (128 bits by default). It is built from two sub-adders that can use different internal structures. The operand width is cut at a point set by a parameter. The lower segment handles the low-order bits and takes the external carry-in. The upper segment handles the remaining high-order bits, and its carry-in is the lower segment's carry-out. The carry-out of the upper segment is the carry-out of the whole adder.

Each segment is one of two kinds, chosen at elaboration time:

- **Ripple-carry:** a chain of full adders.
- **Carry-lookahead:** built from 4-bit groups. Each bit has a propagate term (a XOR b) and a generate term (a AND b). Each group produces a group generate and a group propagate, and carries pass between groups through those signals. A group narrower than four bits is used when the segment width is not a multiple of four.

An integrator sets the total width, the width of each segment and the kind of each segment. The standard build is a 32-bit ripple segment under a 96-bit lookahead segment. Elaboration stops with an error if the two widths do not add up to the total or if either width is zero.

Top module: `hybrid_adder`

## Requirements
- R1: For any operands a, b and carry-in, {cout, sum} equals a + b + cin as a WIDTH+1-bit unsigned value, in the default build (low 32 bits ripple-carry, high 96 bits lookahead).
- R2: The low segment covers bits [LO_WIDTH-1:0] and receives cin. The high segment's carry-in is the low segment's carry-out. With a = 2^LO_WIDTH - 1, b = 0 and cin = 1, the result is sum = 2^LO_WIDTH and cout = 0.
- R3: cout is the carry-out of the most significant bit of the high segment. With every bit of a set, b = 0 and cin = 1, the result is sum = 0 and cout = 1.
- R4: A segment of kind 0 (ripple-carry) produces the exact sum and carry-out of its slice for any slice inputs.
- R5: A segment of kind 1 (lookahead) produces the exact sum and carry-out of its slice for any slice inputs. The carry out of each 4-bit group equals group generate OR (group propagate AND group carry-in).
- R6: A 4-bit ripple-carry low segment under a 124-bit lookahead high segment meets R1's sum relation.
- R7: A 64-bit lookahead low segment under a 64-bit ripple-carry high segment meets R1's sum relation. This is the reversed order of segment kinds.
- R8: The block holds no state. Outputs follow the present inputs within the same clock cycle, with no clock or reset involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Sum bits |
| cout | output | 1 | Carry out of bit WIDTH-1 |

## Verification
Every result of this adder is combinational, so it is due in the same cycle the operands are applied, with zero register stages. The bench changes the operands just after a rising edge and compares the sum and carry-out at the next falling edge, half a period later. For R8 it also samples one time unit after the change. Each vector is applied at once to three builds with different splits (32/96, 4/124 and reversed-kind 64/64). The expected value is computed in the bench as a plain WIDTH+1-bit addition. The vectors include carries that run across each split point and across the whole width.

// File: rtl/hadd_pkg.sv
package hadd_pkg;
   typedef enum int {
      SEG_RIPPLE    = 0,
      SEG_LOOKAHEAD = 1
   } seg_kind_e;

   localparam int GRP_W = 4;

   function automatic int grp_count(input int w);
      return (w + GRP_W - 1) / GRP_W;
   endfunction

   function automatic int grp_width(input int w, input int k);
      int rest;
      rest = w - k * GRP_W;
      return (rest < GRP_W) ? rest : GRP_W;
   endfunction
endpackage

// File: rtl/hadd_ripple_seg.sv
module hadd_ripple_seg #(
   parameter int W = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   output logic [W-1:0] s,
   output logic         cout
);
   logic [W:0] chain;

   assign chain[0] = cin;

   for (genvar i = 0; i < W; i++) begin : g_fa
      logic half;
      assign half         = a[i] ^ b[i];
      assign s[i]         = half ^ chain[i];
      assign chain[i + 1] = (a[i] & b[i]) | (half & chain[i]);
   end

   assign cout = chain[W];

   always_comb begin
      assert_ripple_sum_R4: assert ({cout, s} ==
         ({1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin}))
         else $error("R4 ripple segment sum mismatch");
   end
endmodule

// File: rtl/hadd_cla_group.sv
module hadd_cla_group #(
   parameter int GW = 4
) (
   input  logic [GW-1:0] a,
   input  logic [GW-1:0] b,
   input  logic          cin,
   output logic [GW-1:0] s,
   output logic          grp_gen,
   output logic          grp_prop
);
   logic [GW-1:0] prop;
   logic [GW-1:0] gen;
   logic [GW:0]   cy;

   assign prop = a ^ b;
   assign gen  = a & b;

   always_comb begin
      cy[0] = cin;
      for (int i = 0; i < GW; i++) begin
         cy[i + 1] = gen[i] | (prop[i] & cy[i]);
      end
   end

   assign s = prop ^ cy[GW-1:0];

   always_comb begin
      grp_gen = 1'b0;
      for (int i = 0; i < GW; i++) begin
         grp_gen = gen[i] | (prop[i] & grp_gen);
      end
      grp_prop = &prop;
   end

   always_comb begin
      assert_group_carry_R5: assert (cy[GW] == (grp_gen | (grp_prop & cin)))
         else $error("R5 group carry disagrees with group generate/propagate");
   end
endmodule

// File: rtl/hadd_lookahead_seg.sv
module hadd_lookahead_seg
   import hadd_pkg::*;
#(
   parameter int W = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   output logic [W-1:0] s,
   output logic         cout
);
   localparam int NG = grp_count(W);

   logic [NG:0]   gcarry;
   logic [NG-1:0] ggen;
   logic [NG-1:0] gprop;

   assign gcarry[0] = cin;

   for (genvar k = 0; k < NG; k++) begin : g_grp
      localparam int LO = k * GRP_W;
      localparam int GW = grp_width(W, k);
      hadd_cla_group #(.GW(GW)) u_grp (
         .a        (a[LO +: GW]),
         .b        (b[LO +: GW]),
         .cin      (gcarry[k]),
         .s        (s[LO +: GW]),
         .grp_gen  (ggen[k]),
         .grp_prop (gprop[k])
      );
      assign gcarry[k + 1] = ggen[k] | (gprop[k] & gcarry[k]);
   end

   assign cout = gcarry[NG];

   always_comb begin
      assert_lookahead_sum_R5: assert ({cout, s} ==
         ({1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin}))
         else $error("R5 lookahead segment sum mismatch");
   end
endmodule

// File: rtl/hadd_segment.sv
module hadd_segment
   import hadd_pkg::*;
#(
   parameter seg_kind_e KIND = SEG_RIPPLE,
   parameter int        W    = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   output logic [W-1:0] s,
   output logic         cout
);
   if (KIND == SEG_LOOKAHEAD) begin : g_cla
      hadd_lookahead_seg #(.W(W)) u_seg (
         .a(a), .b(b), .cin(cin), .s(s), .cout(cout));
   end else begin : g_rca
      hadd_ripple_seg #(.W(W)) u_seg (
         .a(a), .b(b), .cin(cin), .s(s), .cout(cout));
   end
endmodule

// File: rtl/hybrid_adder.sv
module hybrid_adder
   import hadd_pkg::*;
#(
   parameter int        WIDTH    = 128,
   parameter seg_kind_e LO_KIND  = SEG_RIPPLE,
   parameter int        LO_WIDTH = 32,
   parameter seg_kind_e HI_KIND  = SEG_LOOKAHEAD,
   parameter int        HI_WIDTH = 96
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             cin,
   output logic [WIDTH-1:0] sum,
   output logic             cout
);
   if (LO_WIDTH + HI_WIDTH != WIDTH) begin : g_bad_split
      $error("segment widths must add up to WIDTH");
   end
   if (LO_WIDTH < 1 || HI_WIDTH < 1) begin : g_bad_width
      $error("each segment must be at least one bit wide");
   end

   logic mid_carry;

   hadd_segment #(.KIND(LO_KIND), .W(LO_WIDTH)) u_lo (
      .a    (a[LO_WIDTH-1:0]),
      .b    (b[LO_WIDTH-1:0]),
      .cin  (cin),
      .s    (sum[LO_WIDTH-1:0]),
      .cout (mid_carry)
   );

   hadd_segment #(.KIND(HI_KIND), .W(HI_WIDTH)) u_hi (
      .a    (a[WIDTH-1:LO_WIDTH]),
      .b    (b[WIDTH-1:LO_WIDTH]),
      .cin  (mid_carry),
      .s    (sum[WIDTH-1:LO_WIDTH]),
      .cout (cout)
   );

   always_comb begin
      logic [LO_WIDTH:0] lo_ref;
      lo_ref = {1'b0, a[LO_WIDTH-1:0]} + {1'b0, b[LO_WIDTH-1:0]}
               + {{LO_WIDTH{1'b0}}, cin};
      assert_boundary_carry_R2: assert (mid_carry == lo_ref[LO_WIDTH])
         else $error("R2 carry across split point wrong");
      assert_total_sum_R1: assert ({cout, sum} ==
         ({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin}))
         else $error("R1 total sum mismatch");
   end
endmodule

// File: tb/sim_hybrid_adder.sv
module sim_hybrid_adder;
   import hadd_pkg::*;

   localparam int W  = 128;
   localparam int NV = 8;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #5 clk = ~clk;

   logic [W-1:0] a = '0;
   logic [W-1:0] b = '0;
   logic         cin = 1'b0;
   logic [W-1:0] s0, s1, s2;
   logic         c0, c1, c2;

   hybrid_adder u0 (.a(a), .b(b), .cin(cin), .sum(s0), .cout(c0));

   hybrid_adder #(.WIDTH(W), .LO_KIND(SEG_RIPPLE), .LO_WIDTH(4),
                  .HI_KIND(SEG_LOOKAHEAD), .HI_WIDTH(124)) u1 (
      .a(a), .b(b), .cin(cin), .sum(s1), .cout(c1));

   hybrid_adder #(.WIDTH(W), .LO_KIND(SEG_LOOKAHEAD), .LO_WIDTH(64),
                  .HI_KIND(SEG_RIPPLE), .HI_WIDTH(64)) u2 (
      .a(a), .b(b), .cin(cin), .sum(s2), .cout(c2));

   localparam logic [W-1:0] TA [NV] = '{
      128'h0,
      {W{1'b1}},
      128'h0000_0000_0000_0000_0000_0000_FFFF_FFFF,
      128'hAAAA_AAAA_AAAA_AAAA_AAAA_AAAA_AAAA_AAAA,
      {W{1'b1}},
      128'h0000_0000_0000_0000_FFFF_FFFF_FFFF_FFFF,
      128'h0000_0000_0000_0000_0000_0000_0000_000F,
      128'h8000_0000_0000_0000_0000_0000_0000_0001
   };
   localparam logic [W-1:0] TB [NV] = '{
      128'h0,
      128'h0,
      128'h0,
      128'h5555_5555_5555_5555_5555_5555_5555_5555,
      {W{1'b1}},
      128'h0000_0000_0000_0000_0000_0000_0000_0001,
      128'h0,
      128'h8000_0000_0000_0000_0000_0000_0000_7FFF
   };
   localparam logic [NV-1:0] TC = 8'b0101_0110;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;

   function automatic logic [W:0] ref_sum(input logic [W-1:0] x,
                                          input logic [W-1:0] y,
                                          input logic ci);
      return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
   endfunction

   task automatic check(input string tag, input logic [W:0] got,
                        input logic [W:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s actual %h expected %h", tag, got, exp);
      end
   endtask

   task automatic apply_all(input logic [W-1:0] va, input logic [W-1:0] vb,
                            input logic vc);
      logic [W:0] exp;
      @(posedge clk);
      a = va; b = vb; cin = vc;
      exp = ref_sum(va, vb, vc);
      @(negedge clk);
      check("R1 R4 R5 split 32/96", {c0, s0}, exp);
      check("R6 split 4/124", {c1, s1}, exp);
      check("R7 split 64/64", {c2, s2}, exp);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_bad++;
         n_chk++;
         $display("FAIL R8 watchdog actual hung expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 reset-time zero inputs", {c0, s0}, '0);
      rst = 1'b0;

      for (int i = 0; i < NV; i++) begin
         apply_all(TA[i], TB[i], TC[i]);
      end

      // R2: carry across each split point
      apply_all(128'hFFFF_FFFF, 128'h0, 1'b1);
      check("R2 boundary bit 32 set, low zero", {95'h0, s0[32:0]}, {95'h0, 1'b1, 32'h0});
      check("R2 boundary no carry-out", {128'h0, c0}, '0);
      apply_all(128'hF, 128'h0, 1'b1);
      check("R2 boundary 4/124 bit 4", {123'h0, s1[5:0]}, {123'h0, 6'h10});
      apply_all(128'hFFFF_FFFF_FFFF_FFFF, 128'h0, 1'b1);
      check("R2 boundary 64/64 bit 64", {63'h0, s2[65:0]}, {63'h0, 2'b01, 64'h0});

      // R3: carry through the whole width
      apply_all({W{1'b1}}, 128'h0, 1'b1);
      check("R3 cout set, sum zero", {c0, s0}, {1'b1, {W{1'b0}}});

      // R8: outputs valid within the cycle of the input change
      @(posedge clk);
      a = 128'h1234_5678_9ABC_DEF0_0FED_CBA9_8765_4321;
      b = 128'h0F0F_0F0F_F0F0_F0F0_FFFF_0000_1111_EEEE;
      cin = 1'b1;
      #1;
      check("R8 same-cycle result", {c0, s0}, ref_sum(a, b, cin));

      for (int r = 0; r < 300; r++) begin
         logic [W-1:0] ra;
         logic [W-1:0] rb;
         ra = {$urandom, $urandom, $urandom, $urandom};
         rb = {$urandom, $urandom, $urandom, $urandom};
         apply_all(ra, rb, 1'($urandom));
      end

      done = 1'b1;
      summary();
      $finish;
   end
endmodule